// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block watches a bank of general-purpose input lines, organised in groups of sixteen, and turns the chosen trigger condition on each line into a latched pending bit. Each 32-bit register word serves two neighbouring groups. Software programs a trigger code for every run of four adjacent lines, masks or unmasks each line on its own, and acknowledges events by writing ones to the pending word.

Unmasked pending lines are combined into one parent interrupt. A service word names exactly one line to handle: a group number (one-based, so zero means idle) and a pin number inside that group. A companion word shows the same line as a one-hot vector. The first reported group spans two pin banks of eight lines each. The service word still gives the raw pin 0..15, and software tells the banks apart by whether the pin is below eight.

Top module: `gpint_ctrl`

## Requirements
- R1: The trigger word for register group g (covering line groups 2g and 2g+1) sits at byte address 0x200 + 4*g. Line p of line group k uses bit 16*(k mod 2) + p of word k/2. A written trigger word reads back unchanged.
- R2: Each 4-bit trigger field at bits [4*(b/4)+3 : 4*(b/4)] serves the four lines b that share b/4. The codes are 0 = low level, 1 = high level, 2 = falling edge, 4 = rising edge, 6 = either edge. Any other code detects nothing.
- R3: A level trigger sets the pending bit on every clock edge where the level holds, so an acknowledge made while the level holds leaves the bit set.
- R4: An edge trigger compares the input sampled at one clock edge with the input at the previous edge. On a match it sets the pending bit at that same edge. A transition of the wrong direction sets nothing.
- R5: The mask word of register group g is at 0x240 + 4*g, with the same bit layout. A 1 keeps the line out of the service word and the parent interrupt, but its pending bit still latches.
- R6: The pending word of register group g is at 0x260 + 4*g. Writing 1 to a bit clears it unless a trigger hits at the same edge. Writing 0 has no effect.
- R7: The service word at 0x284 holds the group number in bits [7:4] and the pin in bits [3:0], with all other bits zero. The reported line is the lowest-numbered unmasked pending line, so the lowest group wins first and then the lowest pin in it. The group number is the line group index plus one, and the word is 0 when nothing is unmasked and pending.
- R8: Line group 0 reports as group 1 with pins 0..15. Pins 0..7 belong to the first bank and pins 8..15 to the second bank, and the raw pin is reported unchanged (line 10 gives 0x1A).
- R9: The word at 0x288 holds in bits [15:0] a one-hot vector with a bit at the reported pin, and is 0 when the service word is 0.
- R10: The parent interrupt output is high in exactly the cycles in which the service group is nonzero.
- R11: Reset sets every mask bit, clears every pending bit and clears every trigger word.
- R12: Writes to 0x284, 0x288 and unmapped addresses change nothing. Reads of unmapped or misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_GROUPS*16 | Input lines, line 16*k+p is pin p of group k |
| bus_wr_i | input | 1 | Write strobe, taken at the rising clock edge |
| bus_addr_i | input | ADDR_W | Byte address for read and write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Parent interrupt |

## Verification
The bench aims at the places where the arbitration order and the acknowledge timing can go wrong.

- **Priority across groups:** lines are made pending in two neighbouring groups at once. A design that picked the highest group, or mis-offset the upper half of a word, would report 0x45 where 0x35 is due.
- **Level versus edge:** an acknowledge is issued while a high level persists. An edge-like level would drop the bit, and a swapped edge polarity would latch on the wrong transition.
- **Shared trigger field:** a neighbour line sharing one trigger field is also checked.
- **Unlisted code:** the unlisted code 3 must stay silent.
- **Split group and top line:** the split group 1 and the top pin of the last group are exercised, so an off-by-one in the one-based group number or in the pin encoding shows up in the service word.

// File: rtl/gpint_pkg.sv
`timescale 1ns/1ps
package gpint_pkg;

   localparam int unsigned REG_W           = 32;
   localparam int unsigned LINES_PER_GROUP = 16;
   localparam int unsigned LINES_PER_FIELD = 4;
   localparam int unsigned FIELD_W         = 4;
   localparam int unsigned GRP_FIELD_W     = 4;
   localparam int unsigned PIN_FIELD_W     = 4;

   localparam logic [11:0] CFG_BASE  = 12'h200;
   localparam logic [11:0] MASK_BASE = 12'h240;
   localparam logic [11:0] PEND_BASE = 12'h260;
   localparam logic [11:0] SVC_ADDR  = 12'h284;
   localparam logic [11:0] SVCV_ADDR = 12'h288;

   typedef enum logic [FIELD_W-1:0] {
      TRIG_LVL_LO = 4'd0,
      TRIG_LVL_HI = 4'd1,
      TRIG_FALL   = 4'd2,
      TRIG_RISE   = 4'd4,
      TRIG_ANY    = 4'd6
   } trig_e;

   typedef struct packed {
      logic [GRP_FIELD_W-1:0] group;
      logic [PIN_FIELD_W-1:0] pin;
   } svc_t;

   // Decide whether one line meets its trigger condition this edge.
   function automatic logic trig_hit(input logic [FIELD_W-1:0] code,
                                     input logic now, input logic was);
      logic r;
      case (code)
         TRIG_LVL_LO: r = ~now;
         TRIG_LVL_HI: r = now;
         TRIG_FALL:   r = was & ~now;
         TRIG_RISE:   r = ~was & now;
         TRIG_ANY:    r = was ^ now;
         default:     r = 1'b0;
      endcase
      return r;
   endfunction

   // Lowest set index of a 16-bit vector (0 when empty).
   function automatic logic [PIN_FIELD_W-1:0] low_pin(input logic [LINES_PER_GROUP-1:0] v);
      logic [PIN_FIELD_W-1:0] r;
      r = '0;
      for (int p = LINES_PER_GROUP-1; p >= 0; p--) begin
         if (v[p]) r = PIN_FIELD_W'(p);
      end
      return r;
   endfunction

endpackage

// File: rtl/gpint_trig_field.sv
`timescale 1ns/1ps
module gpint_trig_field
   import gpint_pkg::*;
#(
   parameter int unsigned        LANES   = LINES_PER_FIELD,
   parameter logic [LANES-1:0]   LANE_EN = '1
) (
   input  logic [FIELD_W-1:0] code_i,
   input  logic [LANES-1:0]   now_i,
   input  logic [LANES-1:0]   was_i,
   output logic [LANES-1:0]   hit_o
);

   if (LANES == 0) begin : g_bad_lanes
      $error("gpint_trig_field: LANES must be nonzero");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (LANE_EN[l]) begin : g_live
         assign hit_o[l] = trig_hit(code_i, now_i[l], was_i[l]);
      end else begin : g_dead
         assign hit_o[l] = 1'b0;
      end
   end

endmodule

// File: rtl/gpint_bank.sv
`timescale 1ns/1ps
module gpint_bank
   import gpint_pkg::*;
#(
   parameter logic [REG_W-1:0] LINE_EN = '1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [REG_W-1:0] pins_i,
   input  logic             cfg_we_i,
   input  logic             mask_we_i,
   input  logic             pend_we_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] cfg_o,
   output logic [REG_W-1:0] mask_o,
   output logic [REG_W-1:0] pend_o
);

   localparam int unsigned FIELDS = REG_W / LINES_PER_FIELD;

   function automatic logic [REG_W-1:0] field_keep(input logic [REG_W-1:0] lv);
      logic [REG_W-1:0] r;
      r = '0;
      for (int f = 0; f < int'(FIELDS); f++) begin
         if (|lv[f*LINES_PER_FIELD +: LINES_PER_FIELD]) r[f*FIELD_W +: FIELD_W] = '1;
      end
      return r;
   endfunction

   localparam logic [REG_W-1:0] CFG_KEEP = field_keep(LINE_EN);

   if (FIELDS * LINES_PER_FIELD != REG_W || FIELD_W * FIELDS != REG_W) begin : g_bad_geom
      $error("gpint_bank: trigger fields must tile the register word");
   end

   logic [REG_W-1:0] prev_q;
   logic [REG_W-1:0] cfg_q;
   logic [REG_W-1:0] mask_q;
   logic [REG_W-1:0] pend_q;
   logic [REG_W-1:0] hit;
   logic [REG_W-1:0] pend_clr;

   // Previous sample of the lines; edges compare against it.
   always_ff @(posedge clk_i) begin
      prev_q <= pins_i;
   end

   for (genvar f = 0; f < FIELDS; f++) begin : g_field
      gpint_trig_field #(
         .LANES   (LINES_PER_FIELD),
         .LANE_EN (LINE_EN[f*LINES_PER_FIELD +: LINES_PER_FIELD])
      ) u_field (
         .code_i (cfg_q[f*FIELD_W +: FIELD_W]),
         .now_i  (pins_i[f*LINES_PER_FIELD +: LINES_PER_FIELD]),
         .was_i  (prev_q[f*LINES_PER_FIELD +: LINES_PER_FIELD]),
         .hit_o  (hit[f*LINES_PER_FIELD +: LINES_PER_FIELD])
      );
   end

   assign pend_clr = pend_we_i ? wdata_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q  <= '0;
         mask_q <= LINE_EN;
         pend_q <= '0;
      end else begin
         if (cfg_we_i)  cfg_q  <= wdata_i & CFG_KEEP;
         if (mask_we_i) mask_q <= wdata_i & LINE_EN;
         pend_q <= ((pend_q & ~pend_clr) | hit) & LINE_EN;
      end
   end

   assign cfg_o  = cfg_q;
   assign mask_o = mask_q;
   assign pend_o = pend_q;

   AST_RESET_MASKS_ALL: assert property (@(posedge clk_i) !rst_ni |=> (mask_o == LINE_EN)); // R11
   AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> ((pend_o & $past(pend_clr & ~hit)) == '0)); // R6
   AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> (($past(pend_o) & ~$past(pend_clr) & ~pend_o) == '0)); // R6

endmodule

// File: rtl/gpint_svc_arb.sv
`timescale 1ns/1ps
module gpint_svc_arb
   import gpint_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 10,
   localparam int unsigned NUM_LINES = NUM_GROUPS * LINES_PER_GROUP
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [NUM_LINES-1:0]       active_i,
   output logic                       valid_o,
   output logic [GRP_FIELD_W-1:0]     group_o,
   output logic [PIN_FIELD_W-1:0]     pin_o,
   output logic [LINES_PER_GROUP-1:0] onehot_o
);

   logic [NUM_GROUPS-1:0]             grp_any;
   logic [NUM_GROUPS*PIN_FIELD_W-1:0] grp_pin;
   logic [GRP_FIELD_W-1:0]            sel_grp;
   logic [PIN_FIELD_W-1:0]            sel_pin;
   logic                              any_hit;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_any[g] = |active_i[g*LINES_PER_GROUP +: LINES_PER_GROUP];
      assign grp_pin[g*PIN_FIELD_W +: PIN_FIELD_W] =
         low_pin(active_i[g*LINES_PER_GROUP +: LINES_PER_GROUP]);
   end

   // Walk downward so the lowest group with work is the last one kept.
   always_comb begin
      any_hit = 1'b0;
      sel_grp = '0;
      sel_pin = '0;
      for (int g = int'(NUM_GROUPS) - 1; g >= 0; g--) begin
         if (grp_any[g]) begin
            any_hit = 1'b1;
            sel_grp = GRP_FIELD_W'(g);
            sel_pin = grp_pin[g*PIN_FIELD_W +: PIN_FIELD_W];
         end
      end
   end

   assign valid_o  = any_hit;
   assign group_o  = any_hit ? sel_grp + GRP_FIELD_W'(1) : '0;
   assign pin_o    = any_hit ? sel_pin : '0;
   assign onehot_o = any_hit ? (LINES_PER_GROUP'(1) << sel_pin) : '0;

   AST_SVC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(onehot_o)); // R9
   AST_SVC_NAMES_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |-> active_i[(32'(group_o) - 1) * LINES_PER_GROUP + 32'(pin_o)]); // R7
   AST_SVC_IS_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |-> ((active_i & ~({NUM_LINES{1'b1}} << ((32'(group_o) - 1) * LINES_PER_GROUP + 32'(pin_o)))) == '0)); // R7
   AST_IDLE_MEANS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni) (group_o == '0) |-> (active_i == '0)); // R7

endmodule

// File: rtl/gpint_ctrl.sv
`timescale 1ns/1ps
module gpint_ctrl
   import gpint_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 10,
   parameter int unsigned ADDR_W     = 12,
   localparam int unsigned NUM_LINES = NUM_GROUPS * LINES_PER_GROUP
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_LINES-1:0]  pins_i,
   input  logic                  bus_wr_i,
   input  logic [ADDR_W-1:0]     bus_addr_i,
   input  logic [REG_W-1:0]      bus_wdata_i,
   output logic [REG_W-1:0]      bus_rdata_o,
   output logic                  irq_o
);

   localparam int unsigned NUM_REGS  = (NUM_GROUPS + 1) / 2;
   localparam int unsigned PAD_LINES = NUM_REGS * REG_W;

   if (NUM_GROUPS < 1 || NUM_GROUPS > 15) begin : g_bad_groups
      $error("gpint_ctrl: NUM_GROUPS must lie in 1..15 to fit the group field");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("gpint_ctrl: ADDR_W must be at least 12");
   end

   function automatic logic [ADDR_W-1:0] word_addr(input logic [11:0] base, input int r);
      return ADDR_W'(base) + ADDR_W'(4 * r);
   endfunction

   logic [PAD_LINES-1:0]        pins_pad;
   logic [PAD_LINES-1:0]        cfg_flat;
   logic [PAD_LINES-1:0]        mask_flat;
   logic [PAD_LINES-1:0]        pend_flat;
   logic [NUM_LINES-1:0]        active;
   logic [NUM_REGS-1:0]         cfg_we;
   logic [NUM_REGS-1:0]         mask_we;
   logic [NUM_REGS-1:0]         pend_we;
   logic                        svc_valid;
   svc_t                        svc;
   logic [LINES_PER_GROUP-1:0]  svc_vec;

   if (PAD_LINES > NUM_LINES) begin : g_pad
      assign pins_pad = {{(PAD_LINES - NUM_LINES){1'b0}}, pins_i};
   end else begin : g_nopad
      assign pins_pad = pins_i;
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam logic [REG_W-1:0] LINE_EN =
         ((r + 1) * REG_W <= NUM_LINES) ? {REG_W{1'b1}} : {{(REG_W/2){1'b0}}, {(REG_W/2){1'b1}}};

      assign cfg_we[r]  = bus_wr_i && (bus_addr_i == word_addr(CFG_BASE,  r));
      assign mask_we[r] = bus_wr_i && (bus_addr_i == word_addr(MASK_BASE, r));
      assign pend_we[r] = bus_wr_i && (bus_addr_i == word_addr(PEND_BASE, r));

      gpint_bank #(
         .LINE_EN (LINE_EN)
      ) u_bank (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .pins_i    (pins_pad[r*REG_W +: REG_W]),
         .cfg_we_i  (cfg_we[r]),
         .mask_we_i (mask_we[r]),
         .pend_we_i (pend_we[r]),
         .wdata_i   (bus_wdata_i),
         .cfg_o     (cfg_flat[r*REG_W +: REG_W]),
         .mask_o    (mask_flat[r*REG_W +: REG_W]),
         .pend_o    (pend_flat[r*REG_W +: REG_W])
      );
   end

   assign active = pend_flat[NUM_LINES-1:0] & ~mask_flat[NUM_LINES-1:0];

   gpint_svc_arb #(
      .NUM_GROUPS (NUM_GROUPS)
   ) u_arb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active),
      .valid_o  (svc_valid),
      .group_o  (svc.group),
      .pin_o    (svc.pin),
      .onehot_o (svc_vec)
   );

   assign irq_o = svc_valid;

   always_comb begin
      bus_rdata_o = '0;
      for (int r = 0; r < int'(NUM_REGS); r++) begin
         if (bus_addr_i == word_addr(CFG_BASE, r))  bus_rdata_o = cfg_flat[r*REG_W +: REG_W];
         if (bus_addr_i == word_addr(MASK_BASE, r)) bus_rdata_o = mask_flat[r*REG_W +: REG_W];
         if (bus_addr_i == word_addr(PEND_BASE, r)) bus_rdata_o = pend_flat[r*REG_W +: REG_W];
      end
      if (bus_addr_i == ADDR_W'(SVC_ADDR))  bus_rdata_o = REG_W'(svc);
      if (bus_addr_i == ADDR_W'(SVCV_ADDR)) bus_rdata_o = REG_W'(svc_vec);
   end

   AST_IRQ_TRACKS_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o == (svc.group != '0)); // R10

endmodule

// File: tb/gpint_ctrl_tb.sv
`timescale 1ns/1ps
module gpint_ctrl_tb;

   localparam int NG   = 10;
   localparam int NREG = (NG + 1) / 2;
   localparam int NL   = NG * 16;
   localparam logic [11:0] A_CFG = 12'h200, A_MASK = 12'h240, A_PEND = 12'h260;
   localparam logic [11:0] A_SVC = 12'h284, A_SVCV = 12'h288;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] pins = '1;
   logic          bus_wr = 1'b0;
   logic [11:0]   bus_addr = 12'h284;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   gpint_ctrl #(.NUM_GROUPS(NG), .ADDR_W(12)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .bus_wr_i(bus_wr),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
   );

   // ---------------- reference model ----------------
   logic [31:0]   m_cfg  [NREG];
   logic [31:0]   m_mask [NREG];
   logic [31:0]   m_pend [NREG];
   logic [31:0]   m_hits [NREG];
   logic [NL-1:0] m_prev;

   function automatic logic model_hit(input int code, input logic now, input logic was);
      if (code == 0) return !now;
      if (code == 1) return now;
      if (code == 2) return was && !now;
      if (code == 4) return !was && now;
      if (code == 6) return was != now;
      return 1'b0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) begin
            m_cfg[r] = '0; m_mask[r] = '1; m_pend[r] = '0;
         end
      end else begin
         for (int r = 0; r < NREG; r++) begin
            m_hits[r] = '0;
            for (int b = 0; b < 32; b++)
               m_hits[r][b] = model_hit(int'(m_cfg[r][4*(b/4) +: 4]), pins[r*32+b], m_prev[r*32+b]);
         end
         for (int r = 0; r < NREG; r++) begin
            logic [31:0] clr;
            clr = (bus_wr && bus_addr == A_PEND + 12'(4*r)) ? bus_wdata : 32'h0;
            m_pend[r] = (m_pend[r] & ~clr) | m_hits[r];
            if (bus_wr && bus_addr == A_CFG  + 12'(4*r)) m_cfg[r]  = bus_wdata;
            if (bus_wr && bus_addr == A_MASK + 12'(4*r)) m_mask[r] = bus_wdata;
         end
      end
      m_prev = pins;
   end

   function automatic logic [7:0] model_svc();
      for (int i = 0; i < NL; i++)
         if (m_pend[i/32][i%32] && !m_mask[i/32][i%32]) return {4'(i/16 + 1), 4'(i%16)};
      return 8'h00;
   endfunction

   function automatic logic [31:0] model_read(input logic [11:0] a);
      logic [7:0] s;
      s = model_svc();
      for (int r = 0; r < NREG; r++) begin
         if (a == A_CFG  + 12'(4*r)) return m_cfg[r];
         if (a == A_MASK + 12'(4*r)) return m_mask[r];
         if (a == A_PEND + 12'(4*r)) return m_pend[r];
      end
      if (a == A_SVC)  return {24'h0, s};
      if (a == A_SVCV) return (s[7:4] != 0) ? (32'h1 << s[3:0]) : 32'h0;
      return 32'h0;
   endfunction

   function automatic string tag_of(input logic [11:0] a);
      if (a >= A_CFG  && a < A_CFG  + 12'(4*NREG)) return "R1";
      if (a >= A_MASK && a < A_MASK + 12'(4*NREG)) return "R5";
      if (a >= A_PEND && a < A_PEND + 12'(4*NREG)) return "R6";
      if (a == A_SVC)  return "R7";
      if (a == A_SVCV) return "R9";
      return "R12";
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare against the model on every cycle, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag_of(bus_addr), bus_rdata, model_read(bus_addr));
         check("R10", {31'h0, irq}, {31'h0, model_svc() != 8'h00});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      tick();
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0; bus_addr = A_SVC;
   endtask

   task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
      tick();
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R11 reset state
      rd_check("R11 cfg", A_CFG, 32'h0);
      rd_check("R11 mask", A_MASK, 32'hFFFF_FFFF);
      rd_check("R11 pend", A_PEND, 32'h0);
      rd_check("R7 idle svc", A_SVC, 32'h0);
      check("R10 idle irq", {31'h0, irq}, 32'h0);

      // R1 readback, R3 level high latches while masked
      wr(A_CFG + 12'd8, 32'h6421_6421);
      rd_check("R1 cfg readback", A_CFG + 12'd8, 32'h6421_6421);
      rd_check("R3 level high pend", A_PEND + 12'd8, 32'h000F_000F);
      wr(A_CFG + 12'd8, 32'h0);
      wr(A_PEND + 12'd8, 32'hFFFF_FFFF);
      rd_check("R6 w1c clears", A_PEND + 12'd8, 32'h0);

      // R8 split group 1, R3 ack during held level
      wr(A_CFG, 32'h0000_0100);
      wr(A_MASK, 32'hFFFF_FBFF);
      rd_check("R8 second bank pin", A_SVC, 32'h0000_001A);
      rd_check("R9 vector", A_SVCV, 32'h0000_0400);
      check("R10 irq high", {31'h0, irq}, 32'h1);
      wr(A_PEND, 32'h0000_0400);
      rd_check("R3 ack while level holds", A_PEND, 32'h0000_0F00);
      pins[10] = 1'b0;
      tick();
      wr(A_PEND, 32'h0000_0400);
      rd_check("R3 ack after level gone", A_PEND, 32'h0000_0B00);
      rd_check("R7 masked only", A_SVC, 32'h0);
      pins[10] = 1'b1;
      wr(A_CFG, 32'h0000_0004);
      wr(A_MASK, 32'hFFFF_FFFF);
      wr(A_PEND, 32'hFFFF_FFFF);
      rd_check("R6 cleanup", A_PEND, 32'h0);

      // R4 rising edge only, R5 mask
      pins[0] = 1'b0;
      tick();
      rd_check("R4 falling ignored by rise code", A_PEND, 32'h0);
      pins[0] = 1'b1;
      rd_check("R4 rising latched", A_PEND, 32'h1);
      rd_check("R5 masked no service", A_SVC, 32'h0);
      check("R5 masked no irq", {31'h0, irq}, 32'h0);
      wr(A_MASK, 32'hFFFF_FFFE);
      rd_check("R7 group1 pin0", A_SVC, 32'h10);
      rd_check("R9 pin0 vector", A_SVCV, 32'h1);
      wr(A_PEND, 32'h0);
      rd_check("R6 zero write no effect", A_PEND, 32'h1);
      wr(A_PEND, 32'h1);
      rd_check("R6 cleared svc", A_SVC, 32'h0);
      wr(A_MASK, 32'hFFFF_FFFF);

      // R7 priority across groups, R2 shared field, R4 both edges
      wr(A_CFG + 12'd4, 32'h0060_0020);
      pins[37] = 1'b0; pins[53] = 1'b0;
      rd_check("R4 fall and either", A_PEND + 12'd4, 32'h0020_0020);
      pins[38] = 1'b0;
      rd_check("R2 shared field", A_PEND + 12'd4, 32'h0020_0060);
      wr(A_MASK + 12'd4, 32'hFFDF_FFDF);
      rd_check("R7 lowest group", A_SVC, 32'h35);
      rd_check("R9 vector g3", A_SVCV, 32'h20);
      wr(A_PEND + 12'd4, 32'h20);
      rd_check("R7 next group", A_SVC, 32'h45);
      rd_check("R9 vector g4", A_SVCV, 32'h20);
      wr(A_PEND + 12'd4, 32'h0020_0000);
      pins[53] = 1'b1;
      rd_check("R4 either edge rising", A_PEND + 12'd4, 32'h0020_0040);
      wr(A_MASK + 12'd4, 32'hFFFF_FFFF);
      pins[37] = 1'b1; pins[38] = 1'b1;
      tick();
      wr(A_PEND + 12'd4, 32'hFFFF_FFFF);

      // R2 unlisted code
      wr(A_CFG + 12'd12, 32'h0000_0003);
      pins[96] = 1'b0;
      tick();
      pins[96] = 1'b1;
      tick();
      rd_check("R2 unlisted code silent", A_PEND + 12'd12, 32'h0);

      // R12 ignored writes and unmapped reads
      wr(A_SVC, 32'hFFFF_FFFF);
      wr(A_SVCV, 32'hFFFF_FFFF);
      wr(12'h300, 32'h1234_5678);
      rd_check("R12 unmapped read", 12'h300, 32'h0);
      rd_check("R12 misaligned read", 12'h202, 32'h0);
      rd_check("R12 svc unchanged", A_SVC, 32'h0);

      // R7 top pin of last group
      wr(A_CFG + 12'd16, 32'h4000_0000);
      pins[159] = 1'b0;
      tick();
      pins[159] = 1'b1;
      wr(A_MASK + 12'd16, 32'h7FFF_FFFF);
      rd_check("R7 last group top pin", A_SVC, 32'hAF);
      rd_check("R9 top pin vector", A_SVCV, 32'h8000);
      check("R10 irq last group", {31'h0, irq}, 32'h1);

      // R11 reset mid-run
      tick();
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
      rd_check("R11 mask after reset", A_MASK + 12'd16, 32'hFFFF_FFFF);
      rd_check("R11 pend after reset", A_PEND + 12'd16, 32'h0);
      rd_check("R11 cfg after reset", A_CFG + 12'd16, 32'h0);
      rd_check("R11 svc after reset", A_SVC, 32'h0);

      repeat (4) tick();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule